// File: doc/BRIEF.md
# SPI Master Baud and Enable Front End

This block sits at the head of an SPI master. From the system clock it derives a one-cycle baud tick through a power-of-two divider whose ratio a 3-bit select field picks from 2 up to 256. Every synchronous element behind it runs on this tick as a clock enable, so the tick is the one block clock for the rest of the master.

The enable control is synchronised in two flops. The divider is held cleared while the block is off. After an enable write, the block comes out of reset on the second system clock edge. The divider then runs a full selected period before its first tick. A new divider select is taken only at a tick boundary, so no period is ever cut short.

While no transfer runs, the serial clock sits at the level set by the clock polarity input. The data output shows the end bit of a small holding register: the top bit or the bottom bit, as the bit-order input selects. Turning the block off stops the tick and leaves the outputs idle. It does not erase the holding register.

Top module: `spim_front`

## Requirements
- R1: While `rst_n` is low, `active` and `baud_tick` are 0 and `hold_word` is all zeros.
- R2: When `en` is first sampled high at rising edge e1, `active` is still 0 after e1 and becomes 1 after the next rising edge e2. `active` is never 1 unless `en` was high two edges earlier.
- R3: With select value s, `baud_tick` is high for exactly one cycle in every 2^(s+1) cycles, for s = 0 (÷2) through s = 7 (÷256).
- R4: The divider is cleared while `active` is 0. Counting the first cycle with `active` high as cycle 0, the first tick after an enable comes in cycle 2^(s+1)-1.
- R5: A change of `div_sel` while active leaves the running period at its old length. The new ratio applies from the period that starts after the next tick.
- R6: After `en` is sampled low, `active` falls one edge later, as in R2. From then on `baud_tick` stays 0, and `sclk` and `mosi` hold their idle values.
- R7: A high `ld` at a rising edge loads `ld_word` into `hold_word`, whether or not the block is enabled. Without `ld`, `hold_word` keeps its value, including across a disable and a re-enable.
- R8: `mosi` shows `hold_word[W-1]` when `lsb_first` is 0 and `hold_word[0]` when it is 1. The output is registered, so it lags by one edge.
- R9: `sclk` equals `cpol`, registered, with a lag of one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable control bit |
| div_sel | input | 3 | Divider select, ratio 2^(div_sel+1) |
| cpol | input | 1 | Clock polarity, idle level of `sclk` |
| lsb_first | input | 1 | Bit order: 1 puts the bottom bit on `mosi` |
| ld | input | 1 | Load strobe for the holding register |
| ld_word | input | 8 | Parallel word to load |
| sclk | output | 1 | Serial clock output (idle level) |
| mosi | output | 1 | Serial data output (idle bit) |
| baud_tick | output | 1 | One-cycle divided clock enable |
| active | output | 1 | Block out of reset, clock generation running |
| hold_word | output | 8 | Current holding register contents |

## Verification
The assertions assume that every input is synchronous to `clk` and changes only between edges. They also assume that `div_sel` stays within the eight encoded ratios and that `rst_n` is low at time zero. The bench drives every input on the falling edge and samples on the falling edge. It sets all inputs to known values before it releases reset, and it only ever writes select values from 0 to 7. As a result, the enable-lag, tick-spacing and select-latching properties only ever see clean, edge-aligned input histories.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef enum logic {
        ORDER_MSB = 1'b0,
        ORDER_LSB = 1'b1
    } order_e;

    typedef struct packed {
        logic sync;
        logic act;
    } start_st_t;

endpackage

// File: rtl/spim_start.sv
module spim_start
    import spim_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic active_o
);

    start_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sync = en_i;
        s_d.act  = s_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active_o = s_q.act;

    // R2: release only after enable was seen two edges back
    a_r2_release_lag: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |-> $past(en_i, 2));

    // R6: two low samples of enable force the block off
    a_r6_drop_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !$past(en_i)) |=> !active_o);

endmodule

// File: rtl/spim_baud.sv
module spim_baud #(
    parameter int STAGES = 8,
    localparam int SELW = $clog2(STAGES),
    localparam int CNTW = STAGES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active_i,
    input  logic [SELW-1:0] sel_i,
    output logic            tick_o
);

    typedef struct packed {
        logic [CNTW-1:0] cnt;
        logic [CNTW-1:0] lim;
    } baud_st_t;

    baud_st_t b_d, b_q;
    logic [CNTW:0]   pow_sel;
    logic [CNTW-1:0] lim_sel;

    assign pow_sel = (CNTW+1)'(2) << sel_i;
    assign lim_sel = CNTW'(pow_sel - (CNTW+1)'(1));
    assign tick_o  = active_i && (b_q.cnt == b_q.lim);

    always_comb begin
        b_d = b_q;
        if (!active_i || tick_o) begin
            b_d.cnt = '0;
            b_d.lim = lim_sel;
        end else begin
            b_d.cnt = b_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    // R3: a tick never lasts two cycles
    a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    // R4: the cycle the block wakes carries no tick
    a_r4_clean_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_i) |-> !tick_o);

    // R5: the limit changes only at a boundary or while idle
    a_r5_sel_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && $past(active_i) && !$past(tick_o)) |-> $stable(b_q.lim));

endmodule

// File: rtl/spim_txhold.sv
module spim_txhold
    import spim_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_i,
    input  logic [W-1:0] word_i,
    input  logic         lsb_first_i,
    output logic [W-1:0] data_o,
    output logic         mosi_o
);

    typedef struct packed {
        logic [W-1:0] data;
        logic         mosi;
    } hold_st_t;

    hold_st_t h_d, h_q;
    order_e   order;

    assign order = order_e'(lsb_first_i);

    always_comb begin
        h_d = h_q;
        if (ld_i) h_d.data = word_i;
        h_d.mosi = (order == ORDER_LSB) ? h_q.data[0] : h_q.data[W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign data_o = h_q.data;
    assign mosi_o = h_q.mosi;

    // R7: contents survive any cycle without a load
    a_r7_keep_word: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_i |=> $stable(data_o));

endmodule

// File: rtl/spim_front.sv
module spim_front #(
    parameter int STAGES = 8,
    parameter int W = 8,
    localparam int SELW = $clog2(STAGES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [SELW-1:0] div_sel,
    input  logic            cpol,
    input  logic            lsb_first,
    input  logic            ld,
    input  logic [W-1:0]    ld_word,
    output logic            sclk,
    output logic            mosi,
    output logic            baud_tick,
    output logic            active,
    output logic [W-1:0]    hold_word
);

    logic active_w;
    logic sclk_d, sclk_q;

    spim_start u_start (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en),
        .active_o (active_w)
    );

    spim_baud #(.STAGES(STAGES)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active_w),
        .sel_i    (div_sel),
        .tick_o   (baud_tick)
    );

    spim_txhold #(.W(W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_i        (ld),
        .word_i      (ld_word),
        .lsb_first_i (lsb_first),
        .data_o      (hold_word),
        .mosi_o      (mosi)
    );

    always_comb sclk_d = cpol;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_d;
    end

    assign sclk   = sclk_q;
    assign active = active_w;

    // R9: serial clock rests at the polarity level
    a_r9_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sclk == $past(cpol)));

    // R6: no tick while the block is off
    a_r6_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !baud_tick);

endmodule

// File: tb/sim_spim_front.sv
module sim_spim_front;

    localparam int CLK_PERIOD = 10;
    localparam int PER [8] = '{2, 4, 8, 16, 32, 64, 128, 256};

    logic       clk = 1'b0;
    logic       rst_n, en, cpol, lsb_first, ld;
    logic [2:0] div_sel;
    logic [7:0] ld_word;
    logic       sclk, mosi, baud_tick, active;
    logic [7:0] hold_word;

    int n_chk  = 0;
    int n_fail = 0;

    spim_front u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .div_sel(div_sel), .cpol(cpol),
        .lsb_first(lsb_first), .ld(ld), .ld_word(ld_word), .sclk(sclk),
        .mosi(mosi), .baud_tick(baud_tick), .active(active), .hold_word(hold_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic next_tick(output int d);
        d = 0;
        do begin
            @(negedge clk);
            d++;
        end while (!baud_tick && d < 1000);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1 (run ended)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int d, nt;
        rst_n = 1'b0; en = 1'b0; cpol = 1'b0; lsb_first = 1'b0;
        ld = 1'b0; div_sel = '0; ld_word = '0;
        repeat (3) @(negedge clk);
        chk("R1 active in reset", active, 0);
        chk("R1 tick in reset", baud_tick, 0);
        chk("R1 word in reset", hold_word, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 sclk cpol=0", sclk, 0);

        // table walk: every divider ratio, from a clean enable
        for (int i = 0; i < 8; i++) begin
            int k, fa, ft, st;
            en = 1'b0;
            repeat (4) @(negedge clk);
            div_sel = 3'(i);
            en = 1'b1;
            k = 0; fa = -1; ft = -1; st = -1;
            while (st < 0 && k < 1000) begin
                @(negedge clk);
                k++;
                if (active && fa < 0) fa = k;
                if (baud_tick) begin
                    if (ft < 0) ft = k;
                    else        st = k;
                end
            end
            chk("R2 enable latency", fa, 2);
            chk("R4 first tick after enable", ft, PER[i] + 1);
            chk("R3 tick period", st - ft, PER[i]);
        end

        // R5: select change mid-period
        en = 1'b0;
        repeat (4) @(negedge clk);
        div_sel = 3'd3;
        en = 1'b1;
        next_tick(d);
        repeat (5) @(negedge clk);
        div_sel = 3'd0;
        next_tick(d);
        chk("R5 old period completes", d + 5, 16);
        next_tick(d);
        chk("R5 new period applied", d, 2);

        // R6: disable
        en = 1'b0;
        @(negedge clk);
        chk("R6 active one edge after disable", active, 1);
        @(negedge clk);
        chk("R6 active falls", active, 0);
        nt = 0;
        repeat (20) begin
            @(negedge clk);
            if (baud_tick) nt++;
        end
        chk("R6 no tick while off", nt, 0);
        chk("R6 sclk idle", sclk, 0);

        // R7/R8: holding register and idle data bit
        ld_word = 8'h80; ld = 1'b1;
        @(negedge clk);
        ld = 1'b0; ld_word = 8'hFF;
        chk("R7 load while disabled", hold_word, 8'h80);
        @(negedge clk);
        chk("R8 msb first", mosi, 1);
        lsb_first = 1'b1;
        @(negedge clk);
        chk("R8 lsb first", mosi, 0);
        en = 1'b1;
        repeat (20) @(negedge clk);
        en = 1'b0;
        repeat (4) @(negedge clk);
        chk("R7 kept across enable cycle", hold_word, 8'h80);
        chk("R6 mosi idle after disable", mosi, 0);
        en = 1'b1;
        repeat (3) @(negedge clk);
        ld_word = 8'h01; ld = 1'b1;
        @(negedge clk);
        ld = 1'b0;
        chk("R7 load while enabled", hold_word, 8'h01);
        @(negedge clk);
        chk("R8 lsb first after load", mosi, 1);
        lsb_first = 1'b0;
        @(negedge clk);
        chk("R8 msb first after load", mosi, 0);

        // R9: polarity
        cpol = 1'b1;
        @(negedge clk);
        chk("R9 sclk cpol=1", sclk, 1);
        cpol = 1'b0;
        @(negedge clk);
        chk("R9 sclk back to 0", sclk, 0);

        // R1: reset during operation
        rst_n = 1'b0;
        #1;
        chk("R1 active cleared", active, 0);
        chk("R1 word cleared", hold_word, 0);
        chk("R1 tick cleared", baud_tick, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule